// File: doc/BRIEF.md
# Modem-Side Control Line Responder

This block sits where a modem would sit on a serial link and answers the terminal's control lines the way a data set does. When a call comes in it rings the terminal with a repeating on/off pattern. It raises data-set-ready once the terminal is ready and the line is connected, and raises carrier-detect while the remote carrier is good. It grants clear-to-send either for the whole connection (full duplex) or in answer to each request-to-send (half duplex). When the terminal drops data-terminal-ready it tears the session down and returns to idle.

The block is a synthesizable modem emulator for loopback testing of a terminal-side control sequencer. The incoming-call, line-connected and carrier-valid conditions arrive as plain flags from the test environment. No modulation, carrier detection or character framing is done here. All inputs are taken as synchronous to `clk`. The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the outputs follow the inputs two cycles after reset is deasserted.

Top module: `mdm_ctl_responder`

## Requirements
- R1: While reset is applied and after it is released with all inputs low, `ring_o`, `dsr_o`, `dcd_o` and `cts_o` are all low.
- R2: With `call_i` high and `dtr_i` low, `ring_o` is high for `RING_ON_CYC` cycles (default 8), starting one cycle after the call is seen. It is then low for `RING_OFF_CYC` cycles (default 12), and this cadence repeats.
- R3: `ring_o` goes low in the cycle after `dtr_i` is sampled high or `call_i` is sampled low, and it is never high while `dsr_o` is high.
- R4: `dsr_o` rises only in the cycle after `dtr_i` and `line_up_i` are both sampled high. With `dtr_i` high and `line_up_i` low it stays low.
- R5: `dcd_o` is high only while `dsr_o` is high, and it rises one cycle after `carrier_ok_i` is sampled high in a connected session. A good carrier seen before `dsr_o` rises does not raise `dcd_o` early.
- R6: If `carrier_ok_i` falls during a connected session, `dcd_o` falls one cycle later and `dsr_o` stays high while `dtr_i` stays high.
- R7: One cycle after `dtr_i` is sampled low, `dsr_o`, `dcd_o` and `cts_o` are low and the block is idle again, so a new call rings once more.
- R8: With `full_dup_i` high, `cts_o` equals `dsr_o` for the whole connection, and `rts_i` has no effect.
- R9: With `full_dup_i` low and the session connected, `cts_o` rises `CTS_DLY` cycles (default 3) after `rts_i` is first sampled high. It falls in the same cycle that `rts_i` falls.
- R10: `cts_o` is never high while `dsr_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dtr_i | input | 1 | Terminal ready (data terminal ready) |
| rts_i | input | 1 | Terminal transmit request (request to send) |
| call_i | input | 1 | Incoming call flag |
| line_up_i | input | 1 | Line connected flag |
| carrier_ok_i | input | 1 | Remote carrier meets acceptance criteria |
| full_dup_i | input | 1 | 1 = full duplex, 0 = half duplex |
| ring_o | output | 1 | Ring indication to the terminal |
| dsr_o | output | 1 | Data set ready |
| dcd_o | output | 1 | Data carrier detect |
| cts_o | output | 1 | Clear to send |

## Verification
The control lines are decoded from a single session state register, so a wrong state shows at the ports on the very next cycle. A session stuck in the ringing state keeps pulsing `ring_o` after DTR has risen. A state that skips the line wait raises `dsr_o` before `line_up_i` is seen. A state that keeps the carrier phase leaves `dcd_o` high after the carrier drops or after teardown. A bad ring-phase or CTS-delay counter shifts `ring_o` or `cts_o` edges by whole cycles against the programmed cadence and delay. The bench therefore samples every output at exact cycle offsets from each input change.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  // Session phases of the emulated data set
  typedef enum logic [2:0] {
    SS_IDLE      = 3'd0,
    SS_RING      = 3'd1,
    SS_WAIT_LINE = 3'd2,
    SS_READY     = 3'd3,
    SS_ONLINE    = 3'd4
  } sess_st_t;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    int unsigned w;
    w = $clog2(max_val + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/mdm_session_fsm.sv
module mdm_session_fsm
  import mdm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dtr,
  input  logic call,
  input  logic line_up,
  input  logic carrier_ok,
  output logic ring_en,
  output logic link_up,
  output logic carrier_up
);

  sess_st_t st_q;
  sess_st_t st_d;

  // next-state logic
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SS_IDLE: begin
        if (dtr)       st_d = SS_WAIT_LINE;
        else if (call) st_d = SS_RING;
      end
      SS_RING: begin
        if (dtr)        st_d = SS_WAIT_LINE;
        else if (!call) st_d = SS_IDLE;
      end
      SS_WAIT_LINE: begin
        if (!dtr)         st_d = SS_IDLE;
        else if (line_up) st_d = SS_READY;
      end
      SS_READY: begin
        if (!dtr)            st_d = SS_IDLE;
        else if (carrier_ok) st_d = SS_ONLINE;
      end
      SS_ONLINE: begin
        if (!dtr)             st_d = SS_IDLE;
        else if (!carrier_ok) st_d = SS_READY;
      end
      default: st_d = SS_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SS_IDLE;
    else        st_q <= st_d;
  end

  assign ring_en    = (st_q == SS_RING);
  assign link_up    = (st_q == SS_READY) || (st_q == SS_ONLINE);
  assign carrier_up = (st_q == SS_ONLINE);

endmodule

// File: rtl/mdm_ring_gen.sv
module mdm_ring_gen
  import mdm_pkg::*;
#(
  parameter int unsigned RING_ON_CYC  = 8,
  parameter int unsigned RING_OFF_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic ring
);

  localparam int unsigned MAX_PH = (RING_ON_CYC > RING_OFF_CYC) ? RING_ON_CYC : RING_OFF_CYC;
  localparam int unsigned CW     = cnt_width(MAX_PH);
  localparam logic [CW-1:0] ON_LAST  = CW'(RING_ON_CYC - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(RING_OFF_CYC - 1);

  logic          on_q, on_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // next-state logic
  always_comb begin
    on_d  = on_q;
    cnt_d = cnt_q;
    if (!enable) begin
      on_d  = 1'b1;
      cnt_d = '0;
    end else if (on_q && (cnt_q == ON_LAST)) begin
      on_d  = 1'b0;
      cnt_d = '0;
    end else if (!on_q && (cnt_q == OFF_LAST)) begin
      on_d  = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      on_q  <= on_d;
      cnt_q <= cnt_d;
    end
  end

  assign ring = enable && on_q;

endmodule

// File: rtl/mdm_cts_grant.sv
module mdm_cts_grant
  import mdm_pkg::*;
#(
  parameter int unsigned CTS_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic full_dup,
  input  logic rts,
  output logic cts
);

  logic half_grant;

  generate
    if (CTS_DLY == 0) begin : g_nodly
      assign half_grant = rts;
    end else begin : g_dly
      localparam int unsigned CW = cnt_width(CTS_DLY);
      localparam logic [CW-1:0] DLY_V = CW'(CTS_DLY);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      // counting is only enabled in a half-duplex request
      assign cnt_en = link_up && !full_dup && rts && (cnt_q != DLY_V);

      always_comb begin
        cnt_d = cnt_q;
        if (!link_up || full_dup || !rts) cnt_d = '0;
        else if (cnt_en)                  cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign half_grant = rts && (cnt_q == DLY_V);
    end
  endgenerate

  assign cts = link_up && (full_dup || half_grant);

endmodule

// File: rtl/mdm_ctl_responder.sv
module mdm_ctl_responder #(
  parameter int unsigned RING_ON_CYC  = 8,
  parameter int unsigned RING_OFF_CYC = 12,
  parameter int unsigned CTS_DLY      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dtr_i,
  input  logic rts_i,
  input  logic call_i,
  input  logic line_up_i,
  input  logic carrier_ok_i,
  input  logic full_dup_i,
  output logic ring_o,
  output logic dsr_o,
  output logic dcd_o,
  output logic cts_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_n_s = rst_sync_q[1];

  logic ring_en;
  logic link_up;
  logic carrier_up;

  mdm_session_fsm u_sess (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .dtr        (dtr_i),
    .call       (call_i),
    .line_up    (line_up_i),
    .carrier_ok (carrier_ok_i),
    .ring_en    (ring_en),
    .link_up    (link_up),
    .carrier_up (carrier_up)
  );

  mdm_ring_gen #(
    .RING_ON_CYC  (RING_ON_CYC),
    .RING_OFF_CYC (RING_OFF_CYC)
  ) u_ring (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .enable (ring_en),
    .ring   (ring_o)
  );

  mdm_cts_grant #(
    .CTS_DLY (CTS_DLY)
  ) u_cts (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .link_up  (link_up),
    .full_dup (full_dup_i),
    .rts      (rts_i),
    .cts      (cts_o)
  );

  assign dsr_o = link_up;
  assign dcd_o = carrier_up;

endmodule

// File: rtl/mdm_ctl_responder_chk.sv
module mdm_ctl_responder_chk (
  input logic clk,
  input logic rst_n_s,
  input logic dtr_i,
  input logic rts_i,
  input logic call_i,
  input logic line_up_i,
  input logic carrier_ok_i,
  input logic full_dup_i,
  input logic ring_o,
  input logic dsr_o,
  input logic dcd_o,
  input logic cts_o
);

  p_ring_stop_dtr_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    dtr_i |=> !ring_o);

  p_ring_stop_call_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !call_i |=> !ring_o);

  p_no_ring_linked_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    dsr_o |-> !ring_o);

  p_dsr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dsr_o ##1 dsr_o |-> $past(dtr_i) && $past(line_up_i));

  p_dcd_gate_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    dcd_o |-> dsr_o);

  p_carrier_drop_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    dsr_o && dtr_i && !carrier_ok_i |=> dsr_o && !dcd_o);

  p_teardown_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dtr_i |=> !dsr_o && !dcd_o && !cts_o);

  p_full_cts_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    full_dup_i |-> cts_o == dsr_o);

  p_half_cts_fall_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !full_dup_i && !rts_i |-> !cts_o);

  p_cts_gate_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    cts_o |-> dsr_o);

endmodule

bind mdm_ctl_responder mdm_ctl_responder_chk u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .dtr_i        (dtr_i),
  .rts_i        (rts_i),
  .call_i       (call_i),
  .line_up_i    (line_up_i),
  .carrier_ok_i (carrier_ok_i),
  .full_dup_i   (full_dup_i),
  .ring_o       (ring_o),
  .dsr_o        (dsr_o),
  .dcd_o        (dcd_o),
  .cts_o        (cts_o)
);

// File: tb/tb_mdm_ctl_responder.sv
`timescale 1ns/1ps
module tb_mdm_ctl_responder;

  localparam int ON_C  = 8;
  localparam int OFF_C = 12;
  localparam int DLY_C = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic dtr, rts, call, line_up, carrier_ok, full_dup;
  logic ring, dsr, dcd, cts;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mdm_ctl_responder #(
    .RING_ON_CYC  (ON_C),
    .RING_OFF_CYC (OFF_C),
    .CTS_DLY      (DLY_C)
  ) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .dtr_i        (dtr),
    .rts_i        (rts),
    .call_i       (call),
    .line_up_i    (line_up),
    .carrier_ok_i (carrier_ok),
    .full_dup_i   (full_dup),
    .ring_o       (ring),
    .dsr_o        (dsr),
    .dcd_o        (dcd),
    .cts_o        (cts)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_inputs();
    dtr = 0; rts = 0; call = 0; line_up = 0; carrier_ok = 0; full_dup = 0;
  endtask

  // bring a session up to DSR (no carrier)
  task automatic connect();
    dtr = 1; line_up = 1;
    step(2);
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    step(3);
    chk("R1 ring in reset", ring, 0);
    chk("R1 dsr in reset",  dsr,  0);
    chk("R1 dcd in reset",  dcd,  0);
    chk("R1 cts in reset",  cts,  0);
    rst_n = 1;
    step(4);
    chk("R1 ring after release", ring, 0);
    chk("R1 dsr after release",  dsr,  0);
    chk("R1 cts after release",  cts,  0);
  endtask

  task automatic t_ring_cadence();
    call = 1;
    for (int i = 0; i < ON_C; i++) begin
      step(1);
      chk("R2 ring on phase", ring, 1);
    end
    for (int i = 0; i < OFF_C; i++) begin
      step(1);
      chk("R2 ring off phase", ring, 0);
    end
    step(1);
    chk("R2 ring second burst", ring, 1);
    call = 0;
    step(1);
    chk("R3 ring stops on call clear", ring, 0);
    step(3);
    chk("R3 ring stays off", ring, 0);
  endtask

  task automatic t_answer();
    call = 1;
    step(2);
    chk("R2 ring before answer", ring, 1);
    dtr = 1;
    carrier_ok = 1;
    step(1);
    chk("R3 ring stops on dtr", ring, 0);
    chk("R4 no dsr without line", dsr, 0);
    step(5);
    chk("R4 dsr waits for line", dsr, 0);
    chk("R5 no early dcd", dcd, 0);
    line_up = 1;
    step(1);
    chk("R4 dsr after line up", dsr, 1);
    chk("R5 dcd not with dsr edge", dcd, 0);
    chk("R3 no ring while linked", ring, 0);
    step(1);
    chk("R5 dcd after carrier", dcd, 1);
    carrier_ok = 0;
    step(1);
    chk("R6 dcd drops with carrier", dcd, 0);
    chk("R6 dsr holds on carrier loss", dsr, 1);
    step(3);
    chk("R6 dsr still held", dsr, 1);
    carrier_ok = 1;
    step(1);
    chk("R5 dcd returns", dcd, 1);
    dtr = 0;
    step(1);
    chk("R7 dsr teardown", dsr, 0);
    chk("R7 dcd teardown", dcd, 0);
    chk("R7 ring after teardown with call", ring, 0);
    step(1);
    chk("R7 idle rings again", ring, 1);
    call = 0; carrier_ok = 0; line_up = 0;
    step(2);
  endtask

  task automatic t_full_duplex();
    full_dup = 1;
    dtr = 1;
    step(1);
    chk("R10 cts needs dsr", cts, 0);
    line_up = 1;
    step(1);
    chk("R8 cts with dsr", cts, 1);
    rts = 1;
    step(1);
    chk("R8 rts high no effect", cts, 1);
    rts = 0;
    step(1);
    chk("R8 rts low no effect", cts, 1);
    dtr = 0;
    step(1);
    chk("R7 cts teardown full", cts, 0);
    idle_inputs();
    step(2);
  endtask

  task automatic t_half_duplex();
    full_dup = 0;
    connect();
    chk("R9 cts idle without rts", cts, 0);
    rts = 1;
    for (int i = 1; i < DLY_C; i++) begin
      step(1);
      chk("R9 cts within delay", cts, 0);
    end
    step(1);
    chk("R9 cts after delay", cts, 1);
    step(2);
    chk("R9 cts held", cts, 1);
    rts = 0;
    #1;
    chk("R9 cts falls with rts", cts, 0);
    step(1);
    chk("R9 cts stays low", cts, 0);
    rts = 1;
    step(DLY_C);
    chk("R9 cts second grant", cts, 1);
    dtr = 0;
    step(1);
    chk("R10 cts drops with dsr", cts, 0);
    chk("R7 dsr low", dsr, 0);
    idle_inputs();
    step(2);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ring_cadence();
    t_answer();
    t_full_duplex();
    t_half_duplex();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule